// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block guards a memory space with a small set of programmable address windows. Each window is an inclusive pair of 32-byte-aligned bounds plus a permission word. Software reaches the windows through a narrow indexed register port. It first selects a window by writing the index register, then reads or writes that window's lower bound, upper bound and permission word. A probe register accepts any address and loads the index register with the number of the window that holds it. Two flag bits in the index register report when no window holds the address and when several do.

Alongside the register port, the block judges every bus access. An access carries an address, a kind (read, write or execute), a privilege level (user or kernel) and a secure/non-secure tag. The access is looked up against all enabled windows at once. If exactly one window matches, that window's permission word decides the outcome. If none match, a default attribute word decides. If more than one window matches, the access is a fault, because windows carry no priority. The verdict appears one cycle after the access, as a registered allow or deny pulse, and the address of the last denied access is captured.

Top module: `mpu_region_checker`

## Requirements
- R1: After a synchronous reset, every window is invalid, the default attribute is zero, the index register reads zero, and every access is denied.
- R2: Register port selects are: 0 index, 1 lower bound, 2 upper bound, 3 permission word, 4 probe (write only, reads zero), 5 default attribute. Any other select reads zero and its writes change nothing. A write takes effect on the clock edge that samples it, so it is visible to a read or an access issued on the next cycle. Read data is registered and appears one cycle after the select.
- R3: Bound registers discard address bits [4:0] on write and read those bits back as zero.
- R4: An address lies in a window when lower <= addr <= upper + 31, so the upper bound names the last 32-byte granule of the window.
- R5: A window takes part in matching only when its permission word has bit 0, bit 15 and bit 16 all set.
- R6: A probe write loads index bits [3:0] with the lowest matching window number. Bit 31 is set when no window matches, in which case the index field is 0. Bit 30 is set when more than one window matches. A plain index write clears both flags.
- R7: An access that matches more than one enabled window is denied and raises the overlap flag with the deny.
- R8: An access that matches no enabled window is judged by the default attribute word.
- R9: Permission bits of the deciding attribute are: user read bit 1, user write bit 2, user execute bit 3, kernel execute bit 4, kernel read bit 7, kernel write bit 8. Access kinds are encoded 0 read, 1 write, 2 execute. An access is allowed only when the bit for its kind and privilege is set.
- R10: A non-secure access is denied whenever the deciding attribute has bit 15 (secure) set.
- R11: Each access gives exactly one verdict pulse (allow or deny) on the next cycle. On a deny, the faulting address is captured and held until the next deny.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 3 | Register select for the write |
| reg_wdata | input | 32 | Register write data |
| reg_rsel | input | 3 | Register select for the read |
| reg_rdata | output | 32 | Registered read data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| acc_user | input | 1 | 1 for user privilege, 0 for kernel |
| acc_secure | input | 1 | 1 for secure access |
| chk_valid | output | 1 | Verdict pulse |
| chk_allow | output | 1 | Access permitted |
| chk_deny | output | 1 | Access refused |
| chk_overlap | output | 1 | Refusal caused by multiple matching windows |
| chk_fault_addr | output | 32 | Address of the last refused access |

## Verification
The bench aims accesses at the first and last byte of a window and at the byte just past it. A design that compared against the raw upper bound instead of its granule would wrongly drop the final 31 bytes. Two windows are set to overlap, and both accesses and probes are sent into the shared span. A design that resolved the overlap by priority would allow those accesses and would leave the multi-match flag clear. One window carries a permission word that is missing bit 16, so a design that tested only the valid bit would match it instead of falling back to the default attribute. Every kind, privilege and security combination is swept under two different default attributes, which exposes any swapped permission bit or any missed secure check.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  // register port selects
  localparam logic [2:0] SEL_INDEX   = 3'd0;
  localparam logic [2:0] SEL_LOWER   = 3'd1;
  localparam logic [2:0] SEL_UPPER   = 3'd2;
  localparam logic [2:0] SEL_PERM    = 3'd3;
  localparam logic [2:0] SEL_PROBE   = 3'd4;
  localparam logic [2:0] SEL_DEFAULT = 3'd5;

  // access kinds
  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_EXEC  = 2'd2;

  // permission word bit positions
  localparam int unsigned PB_VALID = 0;
  localparam int unsigned PB_UREAD = 1;
  localparam int unsigned PB_UWRT  = 2;
  localparam int unsigned PB_UEXEC = 3;
  localparam int unsigned PB_KEXEC = 4;
  localparam int unsigned PB_KREAD = 7;
  localparam int unsigned PB_KWRT  = 8;
  localparam int unsigned PB_SEC   = 15;
  localparam int unsigned PB_SID   = 16;

  typedef struct packed {
    logic none;
    logic multi;
  } match_flags_t;
endpackage

// File: rtl/mpu_hit_vector.sv
module mpu_hit_vector #(
  parameter int unsigned NREG = 16,
  parameter int unsigned GW   = 27,
  parameter int unsigned AW   = 32
) (
  input  logic [NREG-1:0][GW-1:0] lower_g,
  input  logic [NREG-1:0][GW-1:0] upper_g,
  input  logic [NREG-1:0]         enabled,
  input  logic [AW-1:0]           addr,
  output logic [NREG-1:0]         hit
);
  localparam int unsigned GB = AW - GW;

  logic [GW-1:0] addr_g;
  assign addr_g = addr[AW-1:GB];

  for (genvar r = 0; r < NREG; r++) begin : g_cmp
    assign hit[r] = enabled[r] && (addr_g >= lower_g[r]) && (addr_g <= upper_g[r]);
  end
endmodule

// File: rtl/mpu_hit_encode.sv
module mpu_hit_encode #(
  parameter int unsigned NREG = 16,
  parameter int unsigned IW   = 4
) (
  input  logic [NREG-1:0]     hit,
  output logic [IW-1:0]       first,
  output mpu_pkg::match_flags_t flags
);
  always_comb begin
    first = '0;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (hit[r]) first = IW'(r);
    end
  end

  assign flags.none  = (hit == '0);
  assign flags.multi = ((hit & (hit - NREG'(1))) != '0);
endmodule

// File: rtl/mpu_perm_eval.sv
module mpu_perm_eval #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] attr,
  input  logic [1:0]    kind,
  input  logic          user,
  input  logic          secure,
  output logic          allow
);
  import mpu_pkg::*;

  logic need;

  always_comb begin
    case (kind)
      KIND_READ:  need = user ? attr[PB_UREAD] : attr[PB_KREAD];
      KIND_WRITE: need = user ? attr[PB_UWRT]  : attr[PB_KWRT];
      KIND_EXEC:  need = user ? attr[PB_UEXEC] : attr[PB_KEXEC];
      default:    need = 1'b0;
    endcase
  end

  assign allow = need && (secure || !attr[PB_SEC]);
endmodule

// File: rtl/mpu_region_checker.sv
module mpu_region_checker #(
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = 32,
  parameter int unsigned GB   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_wsel,
  input  logic [AW-1:0] reg_wdata,
  input  logic [2:0]    reg_rsel,
  output logic [AW-1:0] reg_rdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_kind,
  input  logic          acc_user,
  input  logic          acc_secure,
  output logic          chk_valid,
  output logic          chk_allow,
  output logic          chk_deny,
  output logic          chk_overlap,
  output logic [AW-1:0] chk_fault_addr
);
  import mpu_pkg::*;

  localparam int unsigned GW = AW - GB;
  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1;

  // window storage: flops, since every window is compared in parallel
  logic [NREG-1:0][GW-1:0] lower_g;
  logic [NREG-1:0][GW-1:0] upper_g;
  logic [NREG-1:0][AW-1:0] perm;
  logic [NREG-1:0]         enabled;
  logic [AW-1:0]           dflt_attr;
  logic [IW-1:0]           idx_q;
  match_flags_t            idx_flags;
  logic                    idx_ok;

  assign idx_ok = ({1'b0, idx_q} < (IW+1)'(NREG));

  for (genvar r = 0; r < NREG; r++) begin : g_en
    assign enabled[r] = perm[r][PB_VALID] & perm[r][PB_SEC] & perm[r][PB_SID];
  end

  // access lookup
  logic [NREG-1:0] acc_hit;
  logic [IW-1:0]   acc_first;
  match_flags_t    acc_flags;
  logic [AW-1:0]   acc_attr;
  logic            acc_perm_ok;
  logic            acc_allow;

  mpu_hit_vector #(.NREG(NREG), .GW(GW), .AW(AW)) u_acc_hits (
    .lower_g (lower_g),
    .upper_g (upper_g),
    .enabled (enabled),
    .addr    (acc_addr),
    .hit     (acc_hit)
  );

  mpu_hit_encode #(.NREG(NREG), .IW(IW)) u_acc_enc (
    .hit   (acc_hit),
    .first (acc_first),
    .flags (acc_flags)
  );

  always_comb begin
    if (acc_flags.multi)     acc_attr = '0;
    else if (acc_flags.none) acc_attr = dflt_attr;
    else                     acc_attr = perm[acc_first];
  end

  mpu_perm_eval #(.AW(AW)) u_perm (
    .attr   (acc_attr),
    .kind   (acc_kind),
    .user   (acc_user),
    .secure (acc_secure),
    .allow  (acc_perm_ok)
  );

  assign acc_allow = acc_perm_ok && !acc_flags.multi;

  // probe lookup on the write data
  logic [NREG-1:0] prb_hit;
  logic [IW-1:0]   prb_first;
  match_flags_t    prb_flags;

  mpu_hit_vector #(.NREG(NREG), .GW(GW), .AW(AW)) u_prb_hits (
    .lower_g (lower_g),
    .upper_g (upper_g),
    .enabled (enabled),
    .addr    (reg_wdata),
    .hit     (prb_hit)
  );

  mpu_hit_encode #(.NREG(NREG), .IW(IW)) u_prb_enc (
    .hit   (prb_hit),
    .first (prb_first),
    .flags (prb_flags)
  );

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      lower_g   <= '0;
      upper_g   <= '0;
      perm      <= '0;
      dflt_attr <= '0;
      idx_q     <= '0;
      idx_flags <= '0;
    end else if (reg_wr) begin
      case (reg_wsel)
        SEL_INDEX: begin
          idx_q     <= reg_wdata[IW-1:0];
          idx_flags <= '0;
        end
        SEL_LOWER: if (idx_ok) lower_g[idx_q] <= reg_wdata[AW-1:GB];
        SEL_UPPER: if (idx_ok) upper_g[idx_q] <= reg_wdata[AW-1:GB];
        SEL_PERM:  if (idx_ok) perm[idx_q]    <= reg_wdata;
        SEL_PROBE: begin
          idx_q     <= prb_flags.none ? '0 : prb_first;
          idx_flags <= prb_flags;
        end
        SEL_DEFAULT: dflt_attr <= reg_wdata;
        default: ;
      endcase
    end
  end

  // registered read port
  logic [AW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (reg_rsel)
      SEL_INDEX: begin
        rd_mux[IW-1:0] = idx_q;
        rd_mux[AW-1]   = idx_flags.none;
        rd_mux[AW-2]   = idx_flags.multi;
      end
      SEL_LOWER:   if (idx_ok) rd_mux = {lower_g[idx_q], GB'(0)};
      SEL_UPPER:   if (idx_ok) rd_mux = {upper_g[idx_q], GB'(0)};
      SEL_PERM:    if (idx_ok) rd_mux = perm[idx_q];
      SEL_DEFAULT: rd_mux = dflt_attr;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // registered verdict
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_valid      <= 1'b0;
      chk_allow      <= 1'b0;
      chk_deny       <= 1'b0;
      chk_overlap    <= 1'b0;
      chk_fault_addr <= '0;
    end else begin
      chk_valid   <= acc_valid;
      chk_allow   <= acc_valid && acc_allow;
      chk_deny    <= acc_valid && !acc_allow;
      chk_overlap <= acc_valid && acc_flags.multi;
      if (acc_valid && !acc_allow) chk_fault_addr <= acc_addr;
    end
  end
endmodule

// File: rtl/mpu_region_checker_chk.sv
module mpu_region_checker_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    reg_rsel,
  input logic [AW-1:0] reg_rdata,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic          chk_valid,
  input logic          chk_allow,
  input logic          chk_deny,
  input logic          chk_overlap,
  input logic [AW-1:0] chk_fault_addr
);
  assert_one_verdict_R11: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (chk_valid && (chk_allow != chk_deny)));

  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!chk_allow && !chk_deny && !chk_valid));

  assert_fault_capture_R11: assert property (@(posedge clk) disable iff (rst)
    chk_deny |-> (chk_fault_addr == $past(acc_addr)));

  assert_overlap_denies_R7: assert property (@(posedge clk) disable iff (rst)
    chk_overlap |-> chk_deny);

  assert_bound_granule_R3: assert property (@(posedge clk) disable iff (rst)
    ((reg_rsel == 3'd1) || (reg_rsel == 3'd2)) |=> (reg_rdata[4:0] == 5'd0));
endmodule

bind mpu_region_checker mpu_region_checker_chk #(.AW(AW)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .reg_rsel       (reg_rsel),
  .reg_rdata      (reg_rdata),
  .acc_valid      (acc_valid),
  .acc_addr       (acc_addr),
  .chk_valid      (chk_valid),
  .chk_allow      (chk_allow),
  .chk_deny       (chk_deny),
  .chk_overlap    (chk_overlap),
  .chk_fault_addr (chk_fault_addr)
);

// File: tb/mpu_region_checker_tb_top.sv
module mpu_region_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_wsel = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_rsel = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_user = 1'b0;
  logic        acc_secure = 1'b0;
  logic        chk_valid, chk_allow, chk_deny, chk_overlap;
  logic [31:0] chk_fault_addr;

  always #10 clk = ~clk;  // 50 MHz

  mpu_region_checker dut_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
    .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .acc_user(acc_user), .acc_secure(acc_secure),
    .chk_valid(chk_valid), .chk_allow(chk_allow), .chk_deny(chk_deny),
    .chk_overlap(chk_overlap), .chk_fault_addr(chk_fault_addr)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_lo [16];
  logic [31:0] m_hi [16];
  logic [31:0] m_perm [16];
  logic [31:0] m_dflt;
  int          m_idx;
  bit          m_none, m_multi;
  logic [31:0] e_rdata, e_fault;
  bit          e_valid, e_allow, e_deny, e_ovl;
  bit          started = 0;
  string       cur_req = "R1";
  int          vectors = 0;
  int          errors = 0;

  function automatic bit m_inside(int r, logic [31:0] a);
    bit en;
    en = m_perm[r][0] && m_perm[r][15] && m_perm[r][16];
    return en && (a >= m_lo[r]) && (a <= m_hi[r] + 32'd31);
  endfunction

  function automatic int m_count(logic [31:0] a);
    int c = 0;
    for (int r = 0; r < 16; r++) if (m_inside(r, a)) c++;
    return c;
  endfunction

  function automatic int m_lowest(logic [31:0] a);
    for (int r = 0; r < 16; r++) if (m_inside(r, a)) return r;
    return 0;
  endfunction

  function automatic bit m_permit(logic [31:0] at, int k, bit u, bit s);
    int b;
    if (k == 0)      b = u ? 1 : 7;
    else if (k == 1) b = u ? 2 : 8;
    else if (k == 2) b = u ? 3 : 4;
    else return 0;
    if (!s && at[15]) return 0;
    return at[b];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < 16; r++) begin m_lo[r] = 0; m_hi[r] = 0; m_perm[r] = 0; end
      m_dflt = 0; m_idx = 0; m_none = 0; m_multi = 0;
      e_rdata = 0; e_fault = 0; e_valid = 0; e_allow = 0; e_deny = 0; e_ovl = 0;
    end else begin
      int c;
      logic [31:0] at;
      c = m_count(acc_addr);
      at = (c == 0) ? m_dflt : m_perm[m_lowest(acc_addr)];
      e_valid = acc_valid;
      e_ovl   = acc_valid && (c > 1);
      e_allow = acc_valid && (c <= 1) && m_permit(at, int'(acc_kind), acc_user, acc_secure);
      e_deny  = acc_valid && !e_allow;
      if (e_deny) e_fault = acc_addr;
      case (reg_rsel)
        3'd0: e_rdata = 32'(m_idx) | (32'(m_none) << 31) | (32'(m_multi) << 30);
        3'd1: e_rdata = m_lo[m_idx];
        3'd2: e_rdata = m_hi[m_idx];
        3'd3: e_rdata = m_perm[m_idx];
        3'd5: e_rdata = m_dflt;
        default: e_rdata = 0;
      endcase
      if (reg_wr) begin
        case (reg_wsel)
          3'd0: begin m_idx = int'(reg_wdata[3:0]); m_none = 0; m_multi = 0; end
          3'd1: m_lo[m_idx] = reg_wdata & ~32'h1f;
          3'd2: m_hi[m_idx] = reg_wdata & ~32'h1f;
          3'd3: m_perm[m_idx] = reg_wdata;
          3'd4: begin
            c = m_count(reg_wdata);
            m_none = (c == 0); m_multi = (c > 1);
            m_idx = (c == 0) ? 0 : m_lowest(reg_wdata);
          end
          3'd5: m_dflt = reg_wdata;
          default: ;
        endcase
      end
    end
    started = 1;
  end

  task automatic cmp1(string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      vectors++;
      cmp1("reg_rdata", reg_rdata, e_rdata);
      cmp1("chk_valid", 32'(chk_valid), 32'(e_valid));
      cmp1("chk_allow", 32'(chk_allow), 32'(e_allow));
      cmp1("chk_deny", 32'(chk_deny), 32'(e_deny));
      cmp1("chk_overlap", 32'(chk_overlap), 32'(e_ovl));
      cmp1("chk_fault_addr", chk_fault_addr, e_fault);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    @(negedge clk);
    reg_wr = 0; acc_valid = 0; reg_rsel = 3'd0;
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    acc_valid = 0; reg_wr = 1; reg_wsel = sel; reg_wdata = d;
  endtask

  task automatic rd(logic [2:0] sel);
    @(negedge clk);
    acc_valid = 0; reg_wr = 0; reg_rsel = sel;
  endtask

  task automatic acc(logic [31:0] a, logic [1:0] k, logic u, logic s);
    @(negedge clk);
    reg_wr = 0; acc_valid = 1; acc_addr = a; acc_kind = k; acc_user = u; acc_secure = s;
  endtask

  task automatic window(int r, logic [31:0] lo, logic [31:0] hi, logic [31:0] p);
    wr(3'd0, 32'(r)); wr(3'd1, lo); wr(3'd2, hi); wr(3'd3, p);
  endtask

  task automatic sweep_access();
    logic [31:0] pts [10] = '{32'h0000_0FFF, 32'h0000_1000, 32'h0000_1FFF, 32'h0000_2000,
                              32'h0000_3050, 32'h0000_30A0, 32'h0000_31FF, 32'h0000_5010,
                              32'h0000_9000, 32'h0000_3220};
    for (int a = 0; a < 10; a++)
      for (int k = 0; k < 4; k++)
        for (int u = 0; u < 2; u++)
          for (int s = 0; s < 2; s++)
            acc(pts[a], 2'(k), 1'(u), 1'(s));
    idle();
  endtask

  task automatic read_window(int r);
    wr(3'd0, 32'(r));
    for (int s = 0; s < 8; s++) rd(3'(s));
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, everything denied
    cur_req = "R1";
    acc(32'h0000_1000, 2'd0, 1'b0, 1'b1);
    acc(32'h0000_0040, 2'd1, 1'b1, 1'b0);
    idle();
    for (int s = 0; s < 8; s++) rd(3'(s));
    idle();

    // R2 R3: program windows; unused selects ignored
    cur_req = "R2/R3";
    window(0, 32'h0000_1000, 32'h0000_1FFF, 32'h0001_8187);
    window(1, 32'h0000_3000, 32'h0000_30FF, 32'h0001_811B);
    window(2, 32'h0000_3080, 32'h0000_3200, 32'h0001_81FF);
    window(3, 32'h0000_5000, 32'h0000_50FF, 32'h0000_8187);  // R5: no bit 16
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    for (int r = 0; r < 5; r++) read_window(r);

    // R4 R5 R7 R8 R9 R10 R11 with zero default
    cur_req = "R4/R5/R7/R9/R10/R11 default zero";
    sweep_access();

    // R8 R10: default grants kernel rw, secure only
    cur_req = "R8/R10 secure default";
    wr(3'd5, 32'h0001_8180);
    rd(3'd5);
    sweep_access();

    // R8 R9: default non-secure with user rw and execute
    cur_req = "R8/R9 open default";
    wr(3'd5, 32'h0000_019E);
    sweep_access();

    // R6: probes, then plain index write clears flags
    cur_req = "R6";
    begin
      logic [31:0] pp [6] = '{32'h0000_1000, 32'h0000_1FFF, 32'h0000_2000,
                              32'h0000_30C0, 32'h0000_3210, 32'h0000_5000};
      for (int i = 0; i < 6; i++) begin
        wr(3'd4, pp[i]); rd(3'd0); rd(3'd1); idle();
      end
    end
    wr(3'd0, 32'h0000_0002); rd(3'd0); idle();
    rd(3'd4); idle();

    // R1: reset again clears everything
    cur_req = "R1 re-reset";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    acc(32'h0000_1000, 2'd0, 1'b0, 1'b1);
    rd(3'd3); rd(3'd5); idle(); idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule